// File: doc/BRIEF.md
# Wired-to-Message Interrupt Converter

This block watches a bank of wired interrupt lines and turns each request into a posted message for a downstream interrupt translation unit. Each implemented line has its own programmable identifier pair: a 12-bit device identifier and a 10-bit event identifier. The message port carries only these two fields, because the doorbell address the message is aimed at is fixed in hardware. Each line can be set to fire on a high level or on a rising edge. A request is held in a per-line pending bit until software clears it through a write-one-to-clear bank.

Lines are numbered globally. Numbers 0 to 63 are reserved and have no hardware. Implemented line p belongs to node (p-64)/128+1 at local index (p-64) mod 128. Each node has a 4 KB register window, and the windows sit back to back. The parameter NODES sets how many nodes exist. Line p therefore appears on input bit p-64. Software reaches the registers over a simple 32-bit bus: a request with a write enable, with read data returned one cycle later. Messages leave on a valid/ready port. When several lines are waiting, a round-robin arbiter picks which one is sent.

Top module: `wire_msg_conv`

## Requirements
- R1: After reset all identifier registers and trigger-select bits read zero (rising-edge mode), no line is pending, and msg_valid is low.
- R2: The identifier register of line p is at byte address 0x1000*n + 0x200 + 4*l, where n is the node index and l the local index. Bits [11:0] hold the device identifier and bits [21:12] the event identifier. Bits [31:22] read zero.
- R3: The trigger-select word for local lines 32w to 32w+31 is at 0x1000*n + 4*w, with local line l at bit l mod 32. A 1 selects high-level trigger and a 0 selects rising-edge trigger.
- R4: A rising-edge line sets its pending bit when its input is high and was low in the previous cycle. Setting the bit produces exactly one message. Further edges while the bit is pending produce none.
- R5: A high-level line sets its pending bit while its input is high. If the input is still high when its pending bit is cleared, the bit sets again and one new message is sent.
- R6: The clear bank word for global lines 32k to 32k+31 is at 0xA000 + 4*k, with line p at bit p mod 32. Writing 1 clears that pending bit, writing 0 has no effect, and reads return zero.
- R7: A message carries the device and event identifiers that were in the line's register when the line was granted.
- R8: Waiting lines are granted round-robin. The search starts one line above the last granted line, wraps from the highest implemented line to the lowest, and takes the first waiting line it finds.
- R9: While msg_valid is high and msg_ready is low, msg_valid and both identifiers stay unchanged.
- R10: Reserved node 0, nodes above NODES, unmapped offsets, clear words outside the implemented lines, and addresses that are not word-aligned read zero, and writes to them are ignored.
- R11: A read returns its data on bus_rdata in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 128*NODES | Wired request lines; bit i is global line 64+i, already synchronous |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | Downstream accepts the offered message |
| msg_devid | output | 12 | Device identifier of the offered message |
| msg_evid | output | 10 | Event identifier of the offered message |

## Verification
The bench holds an edge-mode line high across a clear. A design that treats edge lines as level lines would send a second message there. It also pulses an edge-mode line while its bit is still pending; a design without the sent marker would send duplicates. A level-mode line that is still high is cleared, which must cause exactly one new message. The same line is then written with zeros in the clear bank, where a design that clears on any write would send a spurious message. Three lines that lie across the node boundary and the wrap point are raised together under backpressure. This exposes a fixed-priority arbiter through the grant order, and a message that changes while stalled through its identifiers, including after its register is rewritten mid-stall.

// File: rtl/wmc_pkg.sv
package wmc_pkg;
  localparam int PINS_PER_NODE = 128;
  localparam int RSVD_PINS     = 64;
  localparam int WORD_BITS     = 32;
  localparam int ADDR_W        = 16;
  localparam int DEVID_W       = 12;
  localparam int EVID_W        = 10;
  localparam int VEC_W         = DEVID_W + EVID_W;
  localparam logic [3:0] CLR_PAGE = 4'hA;
  localparam logic [2:0] VEC_SEL  = 3'b001;

  typedef struct packed {
    logic [EVID_W-1:0]  evid;
    logic [DEVID_W-1:0] devid;
  } vec_t;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_TYPE,
    ACC_VEC,
    ACC_CLR
  } acc_e;
endpackage

// File: rtl/wmc_regs.sv
module wmc_regs
  import wmc_pkg::*;
#(
  parameter  int NODES = 2,
  localparam int N     = NODES * PINS_PER_NODE,
  localparam int IW    = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_BITS-1:0] bus_wdata,
  output logic [WORD_BITS-1:0] bus_rdata,
  input  logic [IW-1:0]        rd_idx,
  output vec_t                 rd_vec,
  output logic [N-1:0]         trig_level,
  output logic [N-1:0]         clr_mask
);
  localparam int TWORDS  = PINS_PER_NODE / WORD_BITS;
  localparam int TW_W    = $clog2(TWORDS);
  localparam int LP_W    = $clog2(PINS_PER_NODE);
  localparam int CWORDS  = N / WORD_BITS;
  localparam int CW_BASE = RSVD_PINS / WORD_BITS;

  logic [3:0]           page;
  logic                 aligned;
  logic                 node_ok;
  int                   tbase;
  int                   cbase;
  int                   word;
  logic [IW-1:0]        vidx;
  acc_e                 acc;
  logic                 wr_en;
  logic                 rd_en;
  logic                 vec_we;
  logic [N-1:0]         type_q;
  logic [N-1:0]         type_nxt;
  vec_t                 vec_q [N];
  logic [WORD_BITS-1:0] rdata_q;
  logic [WORD_BITS-1:0] rd_nxt;

  assign wr_en = bus_req & bus_we;
  assign rd_en = bus_req & ~bus_we;

  // address decode
  always_comb begin
    page    = bus_addr[ADDR_W-1:ADDR_W-4];
    aligned = (bus_addr[1:0] == 2'b00);
    node_ok = (page != 4'd0) && (int'(page) <= NODES);
    word    = int'(bus_addr[11:2]);
    tbase   = ((int'(page) - 1) * TWORDS + int'(bus_addr[TW_W+1:2])) * WORD_BITS;
    vidx    = IW'((int'(page) - 1) * PINS_PER_NODE + int'(bus_addr[LP_W+1:2]));
    cbase   = (word - CW_BASE) * WORD_BITS;
    acc     = ACC_NONE;
    if (!aligned) begin
      acc = ACC_NONE;
    end else if (node_ok && word < TWORDS) begin
      acc = ACC_TYPE;
    end else if (node_ok && bus_addr[11:9] == VEC_SEL) begin
      acc = ACC_VEC;
    end else if (page == CLR_PAGE && word >= CW_BASE && word < CW_BASE + CWORDS) begin
      acc = ACC_CLR;
    end
  end

  // next state
  always_comb begin
    type_nxt = type_q;
    clr_mask = '0;
    vec_we   = 1'b0;
    rd_nxt   = '0;
    unique case (acc)
      ACC_TYPE: begin
        rd_nxt = type_q[tbase +: WORD_BITS];
        if (wr_en) type_nxt[tbase +: WORD_BITS] = bus_wdata;
      end
      ACC_VEC: begin
        rd_nxt[VEC_W-1:0] = vec_q[vidx];
        vec_we = wr_en;
      end
      ACC_CLR: begin
        if (wr_en) clr_mask[cbase +: WORD_BITS] = bus_wdata;
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q  <= '0;
      rdata_q <= '0;
      for (int i = 0; i < N; i++) vec_q[i] <= '0;
    end else begin
      type_q <= type_nxt;
      if (rd_en)  rdata_q     <= rd_nxt;
      if (vec_we) vec_q[vidx] <= vec_t'(bus_wdata[VEC_W-1:0]);
    end
  end

  assign bus_rdata  = rdata_q;
  assign rd_vec     = vec_q[rd_idx];
  assign trig_level = type_q;
endmodule

// File: rtl/wmc_pend.sv
module wmc_pend #(
  parameter  int N  = 256,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic [N-1:0]  trig_level,
  input  logic [N-1:0]  clr_mask,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_idx,
  output logic [N-1:0]  pend,
  output logic [N-1:0]  waiting
);
  logic [N-1:0] in_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_nxt;
  logic [N-1:0] sent_q;
  logic [N-1:0] sent_nxt;
  logic [N-1:0] trig;
  logic [N-1:0] set_new;
  logic [N-1:0] acc_mask;

  always_comb begin
    trig     = (trig_level & irq_in) | (~trig_level & irq_in & ~in_q);
    acc_mask = '0;
    if (acc_valid) acc_mask[acc_idx] = 1'b1;
    // a fresh request: trigger on an idle bit, or on a bit being cleared now
    set_new  = trig & (~pend_q | clr_mask);
    pend_nxt = (pend_q & ~clr_mask) | trig;
    sent_nxt = ~set_new & ~clr_mask & (sent_q | acc_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      pend_q <= '0;
      sent_q <= '0;
    end else begin
      in_q   <= irq_in;
      pend_q <= pend_nxt;
      sent_q <= sent_nxt;
    end
  end

  assign pend    = pend_q;
  assign waiting = pend_q & ~sent_q;
endmodule

// File: rtl/wmc_rr.sv
module wmc_rr
  import wmc_pkg::*;
#(
  parameter  int N  = 256,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  waiting,
  input  logic          msg_ready,
  input  vec_t          gnt_vec,
  output logic [IW-1:0] gnt_idx,
  output logic          msg_valid,
  output vec_t          msg_vec,
  output logic          acc_valid,
  output logic [IW-1:0] acc_idx
);
  logic          found;
  int            cand;
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] ptr_nxt;
  logic          valid_q;
  logic          valid_nxt;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_nxt;
  vec_t          vec_q;
  vec_t          vec_nxt;
  logic          load;

  // rotating search starting at ptr_q
  always_comb begin
    found   = 1'b0;
    gnt_idx = '0;
    cand    = 0;
    for (int k = 0; k < N; k++) begin
      cand = int'(ptr_q) + k;
      if (cand >= N) cand = cand - N;
      if (!found && waiting[cand]) begin
        found   = 1'b1;
        gnt_idx = IW'(cand);
      end
    end
  end

  always_comb begin
    valid_nxt = valid_q;
    idx_nxt   = idx_q;
    vec_nxt   = vec_q;
    ptr_nxt   = ptr_q;
    load      = !valid_q && found;
    if (valid_q && msg_ready) valid_nxt = 1'b0;
    if (load) begin
      valid_nxt = 1'b1;
      idx_nxt   = gnt_idx;
      vec_nxt   = gnt_vec;
      ptr_nxt   = (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      vec_q   <= '0;
      ptr_q   <= '0;
    end else begin
      valid_q <= valid_nxt;
      if (load) begin
        idx_q <= idx_nxt;
        vec_q <= vec_nxt;
        ptr_q <= ptr_nxt;
      end
    end
  end

  assign msg_valid = valid_q;
  assign msg_vec   = vec_q;
  assign acc_valid = valid_q & msg_ready;
  assign acc_idx   = idx_q;
endmodule

// File: rtl/wire_msg_conv.sv
module wire_msg_conv
  import wmc_pkg::*;
#(
  parameter  int NODES = 2,
  localparam int N     = NODES * PINS_PER_NODE,
  localparam int IW    = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         irq_in,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_BITS-1:0] bus_wdata,
  output logic [WORD_BITS-1:0] bus_rdata,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [DEVID_W-1:0]   msg_devid,
  output logic [EVID_W-1:0]    msg_evid
);
  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic [N-1:0]  trig_level;
  logic [N-1:0]  clr_mask;
  logic [N-1:0]  pend;
  logic [N-1:0]  waiting;
  logic [IW-1:0] gnt_idx;
  vec_t          gnt_vec;
  vec_t          out_vec;
  logic          acc_valid;
  logic [IW-1:0] acc_idx;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  wmc_regs #(.NODES(NODES)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .rd_idx     (gnt_idx),
    .rd_vec     (gnt_vec),
    .trig_level (trig_level),
    .clr_mask   (clr_mask)
  );

  wmc_pend #(.N(N)) u_pend (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .irq_in     (irq_in),
    .trig_level (trig_level),
    .clr_mask   (clr_mask),
    .acc_valid  (acc_valid),
    .acc_idx    (acc_idx),
    .pend       (pend),
    .waiting    (waiting)
  );

  wmc_rr #(.N(N)) u_rr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .waiting   (waiting),
    .msg_ready (msg_ready),
    .gnt_vec   (gnt_vec),
    .gnt_idx   (gnt_idx),
    .msg_valid (msg_valid),
    .msg_vec   (out_vec),
    .acc_valid (acc_valid),
    .acc_idx   (acc_idx)
  );

  assign msg_devid = out_vec.devid;
  assign msg_evid  = out_vec.evid;
endmodule

// File: rtl/wmc_chk.sv
module wmc_chk #(
  parameter int N = 256
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] irq_in,
  input logic [N-1:0] pend,
  input logic         bus_req,
  input logic         bus_we,
  input logic [15:0]  bus_addr,
  input logic         msg_valid,
  input logic         msg_ready,
  input logic [11:0]  msg_devid,
  input logic [9:0]   msg_evid
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!msg_valid && pend == '0)); // R1

  AST_SINGLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> !msg_valid); // R4

  AST_PEND_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(irq_in)) == '0)); // R5

  AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pend & $past(pend)) != '0) |-> $past(bus_req && bus_we && bus_addr[15:12] == 4'hA)); // R6

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_devid) && $stable(msg_evid))); // R9
endmodule

bind wire_msg_conv wmc_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .irq_in    (irq_in),
  .pend      (pend),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_devid (msg_devid),
  .msg_evid  (msg_evid)
);

// File: tb/tb_wire_msg_conv.sv
`timescale 1ns/1ps
module tb_wire_msg_conv;
  localparam int NODES = 2;
  localparam int N     = NODES * 128;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] irq_in;
  logic         bus_req;
  logic         bus_we;
  logic [15:0]  bus_addr;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic         msg_valid;
  logic         msg_ready;
  logic [11:0]  msg_devid;
  logic [9:0]   msg_evid;

  int n_chk;
  int n_fail;

  wire_msg_conv #(.NODES(NODES)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_devid(msg_devid), .msg_evid(msg_evid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic next_msg(input int max, output bit got, output logic [11:0] dev, output logic [9:0] ev);
    got = 1'b0; dev = '0; ev = '0;
    for (int i = 0; i < max && !got; i++) begin
      @(negedge clk);
      if (msg_valid) begin
        got = 1'b1; dev = msg_devid; ev = msg_evid;
      end
    end
  endtask

  task automatic count_msgs(input int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (msg_valid && msg_ready) cnt++;
    end
  endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk);
    irq_in[p - 64] = v;
  endtask

  // R1, R2, R3, R6, R10, R11
  task automatic t_regs();
    logic [31:0] d;
    chk(msg_valid == 1'b0, "R1 msg_valid after reset", 32'(msg_valid), 0);
    bus_rd(16'h1218, d); chk(d == 0, "R1 vector of line 70 after reset", d, 0);
    bus_rd(16'h200C, d); chk(d == 0, "R1 type word after reset", d, 0);
    bus_wr(16'h1204, 32'hFFFF_FFFF);
    bus_rd(16'h1204, d); chk(d == 32'h003F_FFFF, "R2 vector width of line 65", d, 32'h003F_FFFF);
    bus_rd(16'h1208, d); chk(d == 0, "R2 neighbour line 66 untouched", d, 0);
    bus_wr(16'h0200, 32'h1234_5678);
    bus_rd(16'h0200, d); chk(d == 0, "R10 reserved node 0", d, 0);
    bus_wr(16'h3200, 32'h1234_5678);
    bus_rd(16'h3200, d); chk(d == 0, "R10 node above NODES", d, 0);
    bus_wr(16'h1206, 32'h0000_0FFF);
    bus_rd(16'h1204, d); chk(d == 32'h003F_FFFF, "R10 misaligned write ignored", d, 32'h003F_FFFF);
    bus_rd(16'h1100, d); chk(d == 0, "R10 unmapped offset", d, 0);
    bus_rd(16'hA008, d); chk(d == 0, "R6 clear bank reads zero", d, 0);
    bus_wr(16'h1004, 32'h8000_0001);
    bus_rd(16'h1004, d); chk(d == 32'h8000_0001, "R3 type word readback / R11 read timing", d, 32'h8000_0001);
    bus_wr(16'h1004, 32'h0);
  endtask

  // R4, R6, R7: line 70 = index 6, node 1 local 6, edge mode
  task automatic t_edge();
    bit got; logic [11:0] dev; logic [9:0] ev; int cnt;
    bus_wr(16'h1218, (32'h155 << 12) | 32'hABC);
    set_pin(70, 1'b1);
    next_msg(10, got, dev, ev);
    chk(got, "R4 edge line message", 32'(got), 1);
    chk(dev == 12'hABC && ev == 10'h155, "R7 edge line identifiers", {ev, dev}, {10'h155, 12'hABC});
    count_msgs(20, cnt); chk(cnt == 0, "R4 steady high edge line silent", cnt, 0);
    set_pin(70, 1'b0); set_pin(70, 1'b1);
    count_msgs(20, cnt); chk(cnt == 0, "R4 new edge while pending silent", cnt, 0);
    bus_wr(16'hA008, 32'h40);
    count_msgs(20, cnt); chk(cnt == 0, "R4 clear without fresh edge silent", cnt, 0);
    set_pin(70, 1'b0); set_pin(70, 1'b1);
    next_msg(10, got, dev, ev);
    chk(got && dev == 12'hABC, "R4 fresh edge after clear", 32'(dev), 32'hABC);
    set_pin(70, 1'b0);
    bus_wr(16'hA008, 32'h40);
  endtask

  // R3, R5, R6: line 300 = index 236, node 2 local 108, type word 3 bit 12
  task automatic t_level();
    bit got; logic [11:0] dev; logic [9:0] ev; int cnt; logic [31:0] d;
    bus_wr(16'h23B0, (32'h2A5 << 12) | 32'h3C3);
    bus_wr(16'h200C, 32'h0000_1000);
    bus_rd(16'h200C, d); chk(d == 32'h1000, "R3 level select readback", d, 32'h1000);
    set_pin(300, 1'b1);
    next_msg(10, got, dev, ev);
    chk(got && dev == 12'h3C3 && ev == 10'h2A5, "R5 level line message", {ev, dev}, {10'h2A5, 12'h3C3});
    count_msgs(20, cnt); chk(cnt == 0, "R5 one message while pending", cnt, 0);
    bus_wr(16'hA024, 32'h0);
    count_msgs(20, cnt); chk(cnt == 0, "R6 zero write has no effect", cnt, 0);
    bus_wr(16'hA024, 32'h0000_1000);
    next_msg(10, got, dev, ev);
    chk(got && dev == 12'h3C3, "R5 re-pend after clear while high", 32'(got), 1);
    count_msgs(10, cnt); chk(cnt == 0, "R5 only one re-pend message", cnt, 0);
    set_pin(300, 1'b0);
    bus_wr(16'hA024, 32'h0000_1000);
    count_msgs(20, cnt); chk(cnt == 0, "R5 clear with input low stays quiet", cnt, 0);
  endtask

  // R7, R8, R9: lines 64 (idx 0), 200 (idx 136), 319 (idx 255), edge mode.
  // The last grant was index 236, so the search starts at 237: order 255, 0, 136.
  task automatic t_rr();
    bit got; logic [11:0] dev; logic [9:0] ev; bit stable;
    bus_wr(16'h1200, 32'h0000_1001);
    bus_wr(16'h2220, 32'h0000_2002);
    bus_wr(16'h23FC, 32'h0000_3003);
    @(negedge clk);
    msg_ready = 1'b0;
    irq_in[0] = 1'b1; irq_in[136] = 1'b1; irq_in[255] = 1'b1;
    repeat (3) @(negedge clk);
    chk(msg_valid && msg_devid == 12'h003, "R8 first grant wraps to line 319", 32'(msg_devid), 3);
    bus_wr(16'h23FC, 32'h0007_7777);
    stable = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!msg_valid || msg_devid != 12'h003 || msg_evid != 10'h003) stable = 1'b0;
    end
    chk(stable, "R9 message held while not ready", 32'(msg_devid), 3);
    chk(msg_evid == 10'h003, "R7 identifiers captured at grant", 32'(msg_evid), 3);
    msg_ready = 1'b1;
    next_msg(10, got, dev, ev);
    chk(got && dev == 12'h001, "R8 second grant line 64", 32'(dev), 1);
    next_msg(10, got, dev, ev);
    chk(got && dev == 12'h002, "R8 third grant line 200", 32'(dev), 2);
    irq_in[0] = 1'b0; irq_in[136] = 1'b0; irq_in[255] = 1'b0;
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; irq_in = '0; bus_req = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0; msg_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(msg_valid == 1'b0, "R1 msg_valid in reset", 32'(msg_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_regs();
    t_edge();
    t_level();
    t_rr();
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule